// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block sits on one memory port and makes the address that the port presents to the array. It can behave as a plain pass-through for an address from outside. It can also capture that address into an internal counter and then step it once per clock. This produces one address per access, so the memory sees a burst of consecutive locations.

A programmable mask picks which address bits take part in counting. A mask bit at one lets its address bit count. A mask bit at zero holds its address bit at the value it was loaded with. The carry skips over the held bits, so the burst wraps inside the window that the mask sets. After reset the mask is all ones, and the counter spans the whole address range.

The address bus is bidirectional. A readback strobe for the counter or for the mask makes the block drive that register onto the bus. While it drives the bus, the block ignores the bus as an input.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the counter becomes 0 and the mask becomes all ones.
- R2: `cnt_clr` high at an edge clears the counter to 0, even if load or increment is also requested. During that cycle `mem_addr` is 0.
- R3: `load_n` low, with `cnt_clr` low and no readback strobe, captures `addr_io` into the counter at the edge. This takes priority over increment. During that cycle `mem_addr` equals `addr_io`.
- R4: `inc_en` high, with no clear and no effective load, puts the current counter value on `mem_addr` and advances the counter at the edge. With the mask all ones, the counter goes from all ones to 0.
- R5: During an increment, counter bits whose mask bit is 0 keep their value. The counting bits form one binary number whose carry jumps over the held bits, and that number wraps to 0 after its top value. For example, mask 0x0F and counter 0x3F give 0x30. Mask 0xA5 and counter 0x5F give 0x7A.
- R6: `mask_wr` high, with no readback strobe, writes `addr_io` into the mask at the edge.
- R7: With no clear, no load, no increment and no readback strobe, `mem_addr` equals `addr_io` and the counter holds its value.
- R8: With `rd_cnt` high, the block drives the counter onto `addr_io`. With only `rd_mask` high, it drives the mask onto `addr_io`. While either strobe is high and no clear, load or increment applies, `mem_addr` shows the counter. With neither strobe high, the block leaves `addr_io` undriven.
- R9: While either readback strobe is high, `load_n` and `mask_wr` change neither the counter nor the mask.
- R10: When `rd_cnt` and `rd_mask` are both high, `rd_conflict` is 1 and `addr_io` carries the counter. Otherwise `rd_conflict` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_clr | input | 1 | Clear the counter (highest priority) |
| load_n | input | 1 | Load the counter from the bus, active low |
| inc_en | input | 1 | Advance the counter on each edge |
| mask_wr | input | 1 | Write the mask from the bus |
| rd_cnt | input | 1 | Drive the counter onto the bus |
| rd_mask | input | 1 | Drive the mask onto the bus |
| addr_io | inout | ADDR_W | Bidirectional address bus |
| mem_addr | output | ADDR_W | Address presented to the memory |
| rd_conflict | output | 1 | Both readback strobes are high |

## Verification
The assertions take for granted that the external driver releases `addr_io` whenever a readback strobe is high. Their bus-capture checks also assume that every control input is a known 0 or 1 at each edge once reset is released. The bench drives the bus only in cycles with no readback strobe, and floats it in every readback cycle. It changes controls only just after a rising edge. It holds every control at a defined level from time zero.

// File: rtl/burst_pkg.sv
// Package: shared encoding of the counter operation chosen each cycle.
// Assumes: one operation per cycle, picked by the control decoder.
package burst_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_CLR  = 2'd1,
        OP_LOAD = 2'd2,
        OP_INC  = 2'd3
    } op_e;
endpackage

// File: rtl/burst_ctrl.sv
// Module: burst_ctrl
// Decodes the raw controls into one counter operation by priority:
// clear, then load, then increment, then hold. A readback strobe blocks
// every capture from the bus (load and mask write).
// Assumes: controls are synchronous to clk.
module burst_ctrl
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clr,
    input  logic load_n,
    input  logic inc_en,
    input  logic mask_wr,
    input  logic rd_cnt,
    input  logic rd_mask,
    output op_e  op,
    output logic mask_we,
    output logic rd_any,
    output logic sel_mask,
    output logic conflict
);
    logic load_ok;

    // Readback state and the legality flag
    always_comb begin
        rd_any   = rd_cnt | rd_mask;
        conflict = rd_cnt & rd_mask;
        sel_mask = rd_mask & ~rd_cnt;
        load_ok  = ~load_n & ~rd_any;
        mask_we  = mask_wr & ~rd_any;
    end

    // Priority decode of the counter operation
    always_comb begin
        if (cnt_clr)      op = OP_CLR;
        else if (load_ok) op = OP_LOAD;
        else if (inc_en)  op = OP_INC;
        else              op = OP_HOLD;
    end

    // R9
    rd_blocks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |-> (op != OP_LOAD) && !mask_we);

    // R2
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> (op == OP_CLR));
endmodule

// File: rtl/burst_counter.sv
// Module: burst_counter
// Holds the burst counter and the mask register. It computes the next
// counter value, with the carry skipping over masked-off bits, and it
// selects the address that goes to the memory.
// Assumes: op and mask_we come from burst_ctrl; din is the bus value.
module burst_counter
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic              mask_we,
    input  logic              rd_any,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] cnt,
    output logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ZERO     = {ADDR_W{1'b0}};

    logic [ADDR_W-1:0] cnt_step;
    logic [ADDR_W-1:0] cnt_nxt;

    // Masked increment: held bits forced to one so the carry jumps over them
    always_comb begin
        cnt_step = (((cnt | ~mask) + 1'b1) & mask) | (cnt & ~mask);
    end

    // Next counter value by operation
    always_comb begin
        case (op)
            OP_CLR:  cnt_nxt = ZERO;
            OP_LOAD: cnt_nxt = din;
            OP_INC:  cnt_nxt = cnt_step;
            default: cnt_nxt = cnt;
        endcase
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= ZERO;
        else        cnt <= cnt_nxt;
    end

    // Mask register, all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= ALL_ONES;
        else if (mask_we) mask <= din;
    end

    // Address to the memory
    always_comb begin
        case (op)
            OP_CLR:  mem_addr = ZERO;
            OP_LOAD: mem_addr = din;
            OP_INC:  mem_addr = cnt;
            default: mem_addr = rd_any ? cnt : din;
        endcase
    end

    // R1
    mask_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask == ALL_ONES) && (cnt == ZERO));

    // R2
    clr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) |=> (cnt == ZERO));

    // R3
    load_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (cnt == $past(din)));

    // R4
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && mask == ALL_ONES) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    held_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC) |=> (((cnt ^ $past(cnt)) & ~$past(mask)) == ZERO));

    // R6
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(din)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(cnt));
endmodule

// File: rtl/burst_readback.sv
// Module: burst_readback
// Picks the register to drive back onto the address bus and produces the
// output enable. The counter wins when both strobes are high.
// Assumes: the tristate buffer itself sits at the top level.
module burst_readback #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cnt,
    input  logic [ADDR_W-1:0] mask,
    input  logic              sel_mask,
    input  logic              rd_any,
    output logic              oe,
    output logic [ADDR_W-1:0] dout
);
    // Readback source selection
    always_comb begin
        oe   = rd_any;
        dout = sel_mask ? mask : cnt;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Per-port burst address generator: pass-through, load, masked increment,
// clear, and readback of the counter or mask over a bidirectional bus.
// Assumes: the external driver releases addr_io while a readback strobe is high.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic              load_n,
    input  logic              inc_en,
    input  logic              mask_wr,
    input  logic              rd_cnt,
    input  logic              rd_mask,
    inout  wire  [ADDR_W-1:0] addr_io,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_conflict
);
    op_e               op;
    logic              mask_we;
    logic              rd_any;
    logic              sel_mask;
    logic              oe;
    logic [ADDR_W-1:0] cnt;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] dout;

    burst_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .load_n   (load_n),
        .inc_en   (inc_en),
        .mask_wr  (mask_wr),
        .rd_cnt   (rd_cnt),
        .rd_mask  (rd_mask),
        .op       (op),
        .mask_we  (mask_we),
        .rd_any   (rd_any),
        .sel_mask (sel_mask),
        .conflict (rd_conflict)
    );

    burst_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .mask_we  (mask_we),
        .rd_any   (rd_any),
        .din      (addr_io),
        .cnt      (cnt),
        .mask     (mask),
        .mem_addr (mem_addr)
    );

    burst_readback #(.ADDR_W(ADDR_W)) u_rb (
        .cnt      (cnt),
        .mask     (mask),
        .sel_mask (sel_mask),
        .rd_any   (rd_any),
        .oe       (oe),
        .dout     (dout)
    );

    // Tristate driver onto the shared address bus
    assign addr_io = oe ? dout : {ADDR_W{1'bz}};

    // R10
    conflict_drives_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_conflict |-> oe && (dout == cnt));

    // R8
    mask_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mask && !rd_cnt) |-> oe && (dout == mask));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clr = 1'b0, load_n = 1'b1, inc_en = 1'b0, mask_wr = 1'b0;
    logic rd_cnt = 1'b0, rd_mask = 1'b0;
    logic tb_oe = 1'b1;
    logic [W-1:0] tb_d = '0;
    wire  [W-1:0] addr_io;
    logic [W-1:0] mem_addr;
    logic rd_conflict;

    int checks = 0;
    int errors = 0;

    assign addr_io = tb_oe ? tb_d : {W{1'bz}};

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .load_n(load_n),
        .inc_en(inc_en), .mask_wr(mask_wr), .rd_cnt(rd_cnt), .rd_mask(rd_mask),
        .addr_io(addr_io), .mem_addr(mem_addr), .rd_conflict(rd_conflict)
    );

    typedef struct packed {
        logic [3:0] tag;
        logic clr, ldn, inc, mwr, rdc, rdm, conf;
        logic [W-1:0] din, em, eb;
    } vec_t;

    // Step table, starting after reset: counter 0, mask FF
    localparam vec_t TBL [0:24] = '{
        '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hFE, 8'hFE, 8'hFE}, // R3 load FE
        '{4'd4,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'hFE, 8'h00}, // R4
        '{4'd4,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'hFF, 8'h00}, // R4 FF->00
        '{4'd4,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 8'h00}, // R4
        '{4'd7,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h5A, 8'h5A, 8'h5A}, // R7 pass
        '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h01, 8'h01}, // R8 cnt held
        '{4'd6,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'h0F, 8'h0F, 8'h0F}, // R6 mask 0F
        '{4'd8,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h01, 8'h0F}, // R8 mask
        '{4'd3,  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h3E, 8'h3E, 8'h3E}, // R3 load over inc
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h3E, 8'h00}, // R5
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h3F, 8'h00}, // R5 wrap
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h30, 8'h00}, // R5
        '{4'd6,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'hA5, 8'hA5, 8'hA5}, // R6 mask A5
        '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h5A, 8'h5A, 8'h5A}, // R3
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h5A, 8'h00}, // R5
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h5B, 8'h00}, // R5 skip
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h5E, 8'h00}, // R5
        '{4'd5,  1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h5F, 8'h00}, // R5
        '{4'd9,  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h7A, 8'h7A}, // R9 load ignored
        '{4'd9,  1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 8'h00, 8'h7A, 8'hA5}, // R9 mwr ignored
        '{4'd9,  1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h7A, 8'h7A}, // R9
        '{4'd9,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h7A, 8'hA5}, // R9
        '{4'd10, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'h00, 8'h7A, 8'h7A}, // R10
        '{4'd2,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h44, 8'h00, 8'h44}, // R2
        '{4'd2,  1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'h00}  // R2 result
    };

    task automatic chk(input int tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic l, input logic i, input logic m,
                         input logic rc, input logic rm, input logic [W-1:0] d);
        cnt_clr = c; load_n = l; inc_en = i; mask_wr = m;
        rd_cnt = rc; rd_mask = rm;
        tb_oe = !(rc || rm);
        tb_d = d;
    endtask

    task automatic step_check(input int tag, input logic c, input logic l, input logic i,
                              input logic m, input logic rc, input logic rm,
                              input logic [W-1:0] d, input logic [W-1:0] em,
                              input logic [W-1:0] eb, input logic ec);
        @(posedge clk); #1;
        drive(c, l, i, m, rc, rm, d);
        @(negedge clk);
        chk(tag, "mem_addr", mem_addr, em);
        chk(tag, "addr_io", addr_io, eb);
        chk(tag, "rd_conflict", {{(W-1){1'b0}}, rd_conflict}, {{(W-1){1'b0}}, ec});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive(0, 1, 0, 0, 0, 0, 8'h00);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, seen via readback
        @(negedge clk);
        step_check(1, 0, 1, 0, 0, 1, 0, 8'h00, 8'h00, 8'h00, 1'b0);
        step_check(1, 0, 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'hFF, 1'b0);

        // Table walk; the first row is driven in the cycle after the last readback
        for (int k = 0; k < 25; k++) begin
            step_check(int'(TBL[k].tag), TBL[k].clr, TBL[k].ldn, TBL[k].inc, TBL[k].mwr,
                       TBL[k].rdc, TBL[k].rdm, TBL[k].din, TBL[k].em, TBL[k].eb,
                       TBL[k].conf);
        end

        // R1: reset in mid-operation, after the counter is 33 and the mask is A5
        step_check(3, 0, 0, 0, 0, 0, 0, 8'h33, 8'h33, 8'h33, 1'b0);
        @(posedge clk); #1;
        drive(0, 1, 0, 0, 0, 0, 8'h00);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        step_check(1, 0, 1, 0, 0, 1, 0, 8'h00, 8'h00, 8'h00, 1'b0);
        step_check(1, 0, 1, 0, 0, 0, 1, 8'h00, 8'h00, 8'hFF, 1'b0);
        // R7 pass-through after reset
        step_check(7, 0, 1, 0, 0, 0, 0, 8'hC3, 8'hC3, 8'hC3, 1'b0);
        // R4 full-range step from reset value
        step_check(4, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00, 8'h00, 1'b0);
        step_check(4, 0, 1, 0, 0, 1, 0, 8'h00, 8'h01, 8'h01, 1'b0);

        @(posedge clk); #1;
        drive(0, 1, 0, 0, 0, 0, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule